// File: doc/BRIEF.md
# Shift-Register Controller for a Digital Low-Dropout Regulator

This block is the clocked control core of a digital low-dropout regulator. On each clock edge it takes one decision bit from the output-voltage comparator and updates an active-low enable word. Each bit of that word drives one PMOS current switch in the power array, and the switch is on when its bit is 0. The block does not count. It moves the word up by one place each cycle and writes the newest decision into the bottom bit, so the number of conducting switches changes by at most one per cycle.

A small second group of switch enables bypasses the shift register. These enables take the registered comparator decision directly, so a group of extra switches responds one cycle after a change in the comparator. This shortens the transient response, but it widens the steady-state ripple. The size of the group is derived from the array width.

The comparator, the reference generator, the power array and the output capacitance all sit outside this block.

Top module: `dldo_ctrl`

## Requirements
- R1: A synchronous active-high reset drives every bit of `ctrl_word` to 1 (all array switches off) on the next clock edge, including when reset arrives in the middle of operation.
- R2: While reset is applied, every bit of `direct_en` is 1 (off), whatever value `cmp_hi` has.
- R3: On every clock edge outside reset, `ctrl_word` moves up by one place. The new bit k equals the old bit k-1 for k from 1 to ARRAY_W-1, and the old top bit is discarded.
- R4: The bit written into position 0 equals `cmp_hi` sampled on that edge. A 0 (regulated voltage below reference) turns one more switch on.
- R5: A decision of 1 (regulated voltage above reference) writes 1 into position 0. After ARRAY_W consecutive 1 decisions, the word is all ones whatever it held before.
- R6: Outside reset, every bit of `direct_en` equals `cmp_hi` sampled on the same edge. The width of `direct_en` is ceil(ARRAY_W / DIRECT_DIV), which is 4 by default.
- R7: The number of active switches, which is the count of 0 bits in `ctrl_word`, changes by at most one per cycle. After ARRAY_W consecutive 0 decisions from reset it reaches ARRAY_W, and it stays there while 0 decisions continue.
- R8: In a closed loop, the voltage is modelled as the number of active array switches plus DIRECT_DIV for each cycle the direct group is on, and `cmp_hi` = (model > TARGET). After settling, the active-switch count stays within [TARGET-DIRECT_DIV, TARGET+1], and the comparator keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hi | input | 1 | Comparator decision: 1 means output above reference, 0 means below |
| ctrl_word | output | ARRAY_W | Active-low enables for the array switches (0 = on) |
| direct_en | output | ceil(ARRAY_W/DIRECT_DIV) | Active-low enables for the directly driven switches |

## Verification
The hardest state to reach from the ports is the bounded limit cycle of R8. It only exists when the comparator input is fed back from the block's own outputs, and the direct group's kick is part of that feedback. The bench closes the loop with an arithmetic voltage model. It computes the comparator decision from the observed outputs at each falling edge, lets the loop settle from an all-off start, and then checks the active-switch count against bounds derived from the model. Saturation at both ends is reached with long runs of a single decision. Arbitrary shift histories, including the discarding of the top bit, come from a long pseudo-random decision sequence checked against a shadow word on every cycle.

// File: rtl/dldo_pkg.sv
package dldo_pkg;

  // Comparator decision encoding
  typedef enum logic {
    CMP_BELOW = 1'b0,   // output below reference: add drive
    CMP_ABOVE = 1'b1    // output above reference: remove drive
  } cmp_dec_e;

  // Enable polarity of every switch driven by this block
  localparam logic SW_ON  = 1'b0;
  localparam logic SW_OFF = 1'b1;

  // Ceiling division used to size the direct group
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Map a comparator decision to the enable bit it produces
  function automatic logic dec_to_enable(input cmp_dec_e dec);
    return (dec == CMP_BELOW) ? SW_ON : SW_OFF;
  endfunction

endpackage

// File: rtl/dldo_shift_word.sv
module dldo_shift_word
  import dldo_pkg::*;
#(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             new_bit,
  output logic [WIDTH-1:0] word,
  output logic             spill_bit
);

  // Next word: move every bit up one place, insert at the bottom
  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cur,
                                               input logic             ins);
    logic [WIDTH-1:0] nxt;
    nxt = cur << 1;
    nxt[0] = ins;
    return nxt;
  endfunction

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= {WIDTH{SW_OFF}};
    end else begin
      word_q <= advance(word_q, new_bit);
    end
  end

  assign word      = word_q;
  assign spill_bit = word_q[WIDTH-1];

endmodule

// File: rtl/dldo_direct_drv.sv
module dldo_direct_drv
  import dldo_pkg::*;
#(
  parameter int COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_bit,
  output logic [COUNT-1:0] en_q
);

  // One flop per directly driven switch so each can sit next to its cell
  for (genvar g = 0; g < COUNT; g++) begin : g_direct
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= SW_OFF;
      end else begin
        bit_q <= enable_bit;
      end
    end
    assign en_q[g] = bit_q;
  end

endmodule

// File: rtl/dldo_ctrl.sv
module dldo_ctrl
  import dldo_pkg::*;
#(
  parameter int ARRAY_W    = 13,
  parameter int DIRECT_DIV = 4,
  localparam int DIRECT_W  = (ARRAY_W + DIRECT_DIV - 1) / DIRECT_DIV
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmp_hi,
  output logic [ARRAY_W-1:0]  ctrl_word,
  output logic [DIRECT_W-1:0] direct_en
);

  // Decision decoded once and shared by both paths
  cmp_dec_e dec;
  logic     shift_in_bit;
  logic     dropped_bit;

  assign dec          = cmp_dec_e'(cmp_hi);
  assign shift_in_bit = dec_to_enable(dec);

  dldo_shift_word #(
    .WIDTH (ARRAY_W)
  ) u_word (
    .clk       (clk),
    .rst       (rst),
    .new_bit   (shift_in_bit),
    .word      (ctrl_word),
    .spill_bit (dropped_bit)
  );

  dldo_direct_drv #(
    .COUNT (DIRECT_W)
  ) u_direct (
    .clk        (clk),
    .rst        (rst),
    .enable_bit (shift_in_bit),
    .en_q       (direct_en)
  );

endmodule

// File: rtl/dldo_ctrl_chk.sv
module dldo_ctrl_chk #(
  parameter int ARRAY_W  = 13,
  parameter int DIRECT_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cmp_hi,
  input logic [ARRAY_W-1:0]  ctrl_word,
  input logic [DIRECT_W-1:0] direct_en,
  input logic                shift_in_bit
);

  AST_RESET_ALL_OFF: assert property (@(posedge clk) rst |=> &ctrl_word); // R1
  AST_RESET_DIRECT_OFF: assert property (@(posedge clk) rst |=> &direct_en); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctrl_word[ARRAY_W-1:1] == $past(ctrl_word[ARRAY_W-2:0])); // R3

  AST_BOTTOM_BIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctrl_word[0] == $past(cmp_hi)); // R4

  AST_INSERT_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ctrl_word[0] == $past(shift_in_bit)); // R5

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> direct_en == {DIRECT_W{$past(cmp_hi)}}); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(ctrl_word) + 1 >= $past($countones(ctrl_word))) &&
             ($countones(ctrl_word) <= $past($countones(ctrl_word)) + 1)); // R7

endmodule

bind dldo_ctrl dldo_ctrl_chk #(
  .ARRAY_W  (ARRAY_W),
  .DIRECT_W (DIRECT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmp_hi       (cmp_hi),
  .ctrl_word    (ctrl_word),
  .direct_en    (direct_en),
  .shift_in_bit (shift_in_bit)
);

// File: tb/dldo_ctrl_bench.sv
module dldo_ctrl_bench;

  localparam int W      = 13;
  localparam int DIV    = 4;
  localparam int D      = (W + DIV - 1) / DIV;
  localparam int TARGET = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmp_hi = 1'b0;
  logic [W-1:0] ctrl_word;
  logic [D-1:0] direct_en;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] shadow;
  logic         done = 1'b0;

  always #2.5 clk = ~clk;

  dldo_ctrl #(.ARRAY_W(W), .DIRECT_DIV(DIV)) u_dldo_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmp_hi    (cmp_hi),
    .ctrl_word (ctrl_word),
    .direct_en (direct_en)
  );

  function automatic int zeros(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) if (w[i] == 1'b0) n++;
    return n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one decision, clock it in, sample at the following falling edge
  task automatic step(input logic c);
    cmp_hi = c;
    @(posedge clk);
    @(negedge clk);
    shadow = (rst) ? {W{1'b1}} : ((shadow << 1) | W'(c));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int lo, hi, toggles;
    logic prev_c;
    shadow = '1;
    @(negedge clk);
    // R1/R2: reset with comparator asking for drive
    step(1'b0);
    step(1'b0);
    check("R1 reset word", ctrl_word, {W{1'b1}});
    check("R2 reset direct", direct_en, {D{1'b1}});
    rst = 1'b0;

    // R7: fill with zeros, then hold
    for (int i = 1; i <= W + 4; i++) begin
      step(1'b0);
      check("R4 word after zero", ctrl_word, shadow);
      check("R7 active count", zeros(ctrl_word), (i < W) ? i : W);
      check("R6 direct on", direct_en, {D{1'b0}});
    end

    // R5: ones drain it back
    for (int i = 1; i <= W + 2; i++) begin
      step(1'b1);
      check("R5 word after one", ctrl_word, shadow);
      check("R6 direct off", direct_en, {D{1'b1}});
    end
    check("R5 all off", ctrl_word, {W{1'b1}});

    // R3/R4/R6: pseudo-random decisions
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0]);
      check("R3 shifted word", ctrl_word, shadow);
      check("R6 direct follow", direct_en, {D{lfsr[0]}});
    end

    // R1: reset mid-run
    rst = 1'b1;
    step(1'b0);
    check("R1 mid-run reset", ctrl_word, {W{1'b1}});
    check("R2 mid-run direct", direct_en, {D{1'b1}});
    rst = 1'b0;

    // R8: closed loop
    lo = W; hi = 0; toggles = 0; prev_c = 1'b0;
    for (int i = 0; i < 400; i++) begin
      int v;
      logic c;
      v = zeros(ctrl_word) + ((direct_en[0] == 1'b0) ? DIV : 0);
      c = (v > TARGET);
      step(c);
      if (i >= 100) begin
        if (zeros(ctrl_word) < lo) lo = zeros(ctrl_word);
        if (zeros(ctrl_word) > hi) hi = zeros(ctrl_word);
        if (c != prev_c) toggles++;
      end
      prev_c = c;
    end
    check("R8 lower bound", (lo >= TARGET - DIV) ? 1 : 0, 1);
    check("R8 upper bound", (hi <= TARGET + 1) ? 1 : 0, 1);
    check("R8 keeps toggling", (toggles > 20) ? 1 : 0, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule